// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address and cycle-control front end of a synchronous burst memory. On every rising clock edge it samples two active-low address strobes, a chip enable, a pair of chip selects, an advance input and a static burst-order select. From these it decides whether the cycle starts a new burst, steps an open burst, holds the current beat, or deselects the device.

A new burst loads the external word address. The loaded address is the first beat. Later beats change only the low address bits. A small beat counter and the order select produce those bits, either by counting up or by XOR with the start value. The counter wraps after the last beat. The two strobes are gated differently. The processor strobe acts only while the chip enable is low. The controller strobe acts whatever the chip enable is. Outputs are the internal word address, an active flag and a cycle-kind code. The array, the write datapath and the electrical timing lie outside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in the deselected state: active low, cycle kind 0, internal address 0 and beat counter 0.
- R2: The processor strobe has no effect while the chip enable is high. With the controller strobe high, such a cycle behaves as a step (advance low) or a hold (advance high).
- R3: The controller strobe loads regardless of the chip enable. With the chip enable high it gives a deselect cycle: active goes low and the cycle kind is 0.
- R4: A load with the chip enable low and the chip selects inactive is a deselect: active low, cycle kind 0. The chip selects are inactive when sel_hi is low or sel_lo_n is high.
- R5: A load with the chip enable low, sel_hi high and sel_lo_n low starts a burst. From the next edge the internal address equals the loaded address, and active is high.
- R6: With both strobes high and advance low, the beat counter steps once and the cycle kind is 3.
- R7: With both strobes high and advance high, the internal address and the active flag hold, and the cycle kind is 4.
- R8: Step and hold cycles ignore the chip enable and the chip selects.
- R9: With order_xor low, the low two address bits count up modulo 4 from the start value, for example 01,10,11,00, and then return to 01.
- R10: With order_xor high, the low two bits are the start value XOR 00, 01, 10, 11 in turn, for example 10,11,00,01, and then return to 10.
- R11: A burst started with the processor strobe has cycle kind 1 (read start), whatever wr_n is, and this holds also when both strobes are low. A burst started only by the controller strobe has cycle kind 2 (write start) when wr_n is low and kind 1 when wr_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by chip_en_n |
| ctl_stb_n | input | 1 | Controller address strobe, active low, not gated |
| chip_en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_n | input | 1 | Write request, active low, sampled on controller-started loads |
| order_xor | input | 1 | Static burst order: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External word address |
| int_addr | output | ADDR_W | Internal word address of the current beat |
| active | output | 1 | Device selected with a burst open |
| cyc_kind | output | 3 | Last cycle: 0 deselect, 1 read start, 2 write start, 3 step, 4 hold |

## Verification
The bench uses the default widths: a 16-bit address and 2-bit beats. With these values a full four-beat wrap in either order takes only a few cycles. Checks on the whole address also show that the upper 14 bits never change during a burst. Random phases run with the order select fixed at each value in turn. They reach strobe collisions, loads gated off by the chip enable, and hold cycles in the middle of a wrap, far more often than directed stimulus alone.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_stb_n,
  input  logic              ctl_stb_n,
  input  logic              chip_en_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] int_addr,
  output logic              active,
  output logic [2:0]        cyc_kind
);
  localparam int HI_W = ADDR_W - BEAT_W;
  localparam logic [2:0] K_DESEL = 3'd0;
  localparam logic [2:0] K_RD    = 3'd1;
  localparam logic [2:0] K_WR    = 3'd2;
  localparam logic [2:0] K_STEP  = 3'd3;
  localparam logic [2:0] K_HOLD  = 3'd4;

  logic [HI_W-1:0]   base_hi;
  logic [BEAT_W-1:0] base_lo;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo_bits;

  wire proc_ld  = !proc_stb_n && !chip_en_n;
  wire ctl_ld   = !ctl_stb_n;
  wire load     = proc_ld || ctl_ld;
  wire selected = !chip_en_n && sel_hi && !sel_lo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi  <= '0;
      base_lo  <= '0;
      beat     <= '0;
      active   <= 1'b0;
      cyc_kind <= K_DESEL;
    end else if (load) begin
      if (selected) begin
        base_hi  <= ext_addr[ADDR_W-1:BEAT_W];
        base_lo  <= ext_addr[BEAT_W-1:0];
        beat     <= '0;
        active   <= 1'b1;
        cyc_kind <= (proc_ld || wr_n) ? K_RD : K_WR;
      end else begin
        active   <= 1'b0;
        cyc_kind <= K_DESEL;
      end
    end else if (!adv_n) begin
      beat     <= beat + 1'b1;
      cyc_kind <= K_STEP;
    end else begin
      cyc_kind <= K_HOLD;
    end
  end

  assign lo_bits  = order_xor ? (base_lo ^ beat) : (base_lo + beat);
  assign int_addr = {base_hi, lo_bits};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_stb_n,
  input logic              ctl_stb_n,
  input logic              chip_en_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              adv_n,
  input logic              wr_n,
  input logic              order_xor,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] int_addr,
  input logic              active,
  input logic [2:0]        cyc_kind
);
  logic no_strobe;
  logic good_start;
  assign no_strobe  = ctl_stb_n && (proc_stb_n || chip_en_n);
  assign good_start = !no_strobe && !chip_en_n && sel_hi && !sel_lo_n;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!active && cyc_kind == 3'd0 && int_addr == '0)); // R1
  AST_CTL_DESELECT: assert property (@(posedge clk) disable iff (rst) (!ctl_stb_n && chip_en_n) |=> (!active && cyc_kind == 3'd0)); // R3
  AST_CS_DESELECT: assert property (@(posedge clk) disable iff (rst) (!no_strobe && !chip_en_n && (!sel_hi || sel_lo_n)) |=> (!active && cyc_kind == 3'd0)); // R4
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst) good_start |=> (active && int_addr == $past(ext_addr))); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (no_strobe && adv_n) |=> ($stable(int_addr) && $stable(active) && cyc_kind == 3'd4)); // R7
  AST_STEP_KIND: assert property (@(posedge clk) disable iff (rst) (no_strobe && !adv_n) |=> ($stable(active) && cyc_kind == 3'd3)); // R6
  AST_STEP_UPPER: assert property (@(posedge clk) disable iff (rst) (no_strobe && !adv_n) |=> (int_addr[ADDR_W-1:BEAT_W] == $past(int_addr[ADDR_W-1:BEAT_W]))); // R8
  AST_PROC_READ: assert property (@(posedge clk) disable iff (rst) (good_start && !proc_stb_n) |=> (cyc_kind == 3'd1)); // R11
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        proc_stb_n = 1'b1, ctl_stb_n = 1'b1, chip_en_n = 1'b1;
  logic        sel_hi = 1'b0, sel_lo_n = 1'b1, adv_n = 1'b1, wr_n = 1'b1, order_xor = 1'b0;
  logic [15:0] ext_addr = '0;
  logic [15:0] int_addr;
  logic        active;
  logic [2:0]  cyc_kind;

  int checks = 0;
  int fails  = 0;

  int m_base = 0, m_step = 0, m_kind = 0;
  bit m_act = 0;

  always #2 clk = ~clk;

  burst_addr_seq dut_i (
    .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n),
    .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .adv_n(adv_n),
    .wr_n(wr_n), .order_xor(order_xor), .ext_addr(ext_addr),
    .int_addr(int_addr), .active(active), .cyc_kind(cyc_kind)
  );

  function automatic int model_addr();
    int lo;
    if (order_xor) lo = (m_base % 4) ^ m_step;
    else           lo = ((m_base % 4) + m_step) % 4;
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic model_edge();
    bit pl, cl;
    if (rst) begin
      m_base = 0; m_step = 0; m_act = 0; m_kind = 0;
      return;
    end
    pl = (proc_stb_n == 1'b0) && (chip_en_n == 1'b0);
    cl = (ctl_stb_n == 1'b0);
    if (pl || cl) begin
      if (chip_en_n == 1'b0 && sel_hi == 1'b1 && sel_lo_n == 1'b0) begin
        m_base = int'(ext_addr); m_step = 0; m_act = 1;
        m_kind = (pl || wr_n) ? 1 : 2;
      end else begin
        m_act = 0; m_kind = 0;
      end
    end else if (adv_n == 1'b0) begin
      m_step = (m_step + 1) % 4; m_kind = 3;
    end else begin
      m_kind = 4;
    end
  endtask

  task automatic compare(input string tag);
    int ea;
    ea = model_addr();
    checks++;
    if (int'(int_addr) != ea || active != m_act || int'(cyc_kind) != m_kind) begin
      fails++;
      $display("FAIL %s: addr=%h act=%0b kind=%0d expected addr=%h act=%0b kind=%0d",
               tag, int_addr, active, cyc_kind, ea[15:0], m_act, m_kind);
    end
  endtask

  task automatic cyc(input string tag, input bit pn, input bit cn, input bit cen,
                     input bit shi, input bit slo, input bit av, input bit w,
                     input logic [15:0] a);
    @(negedge clk);
    proc_stb_n = pn; ctl_stb_n = cn; chip_en_n = cen; sel_hi = shi;
    sel_lo_n = slo; adv_n = av; wr_n = w; ext_addr = a;
    @(posedge clk);
    model_edge();
    #1 compare(tag);
  endtask

  task automatic do_reset(input bit ord);
    @(negedge clk);
    rst = 1'b1; order_xor = ord;
    proc_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    @(posedge clk);
    model_edge();
    #1 compare("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R5 R11: processor start, write request ignored
    cyc("R5", 0, 1, 0, 1, 0, 1, 0, 16'h1235);
    // R6 R9: linear steps and wrap
    cyc("R9", 1, 1, 0, 1, 0, 0, 1, 16'h0);
    cyc("R9", 1, 1, 0, 1, 0, 0, 1, 16'h0);
    cyc("R9", 1, 1, 0, 1, 0, 0, 1, 16'h0);
    cyc("R6", 1, 1, 0, 1, 0, 0, 1, 16'h0);
    cyc("R7", 1, 1, 0, 1, 0, 1, 1, 16'hFFFF);
    // R2: processor strobe with chip enable high does nothing
    cyc("R2", 0, 1, 1, 1, 0, 1, 1, 16'h4444);
    cyc("R2", 0, 1, 1, 1, 0, 0, 1, 16'h4444);
    // R8: step with chip enable high and selects inactive
    cyc("R8", 1, 1, 1, 0, 1, 0, 1, 16'h7777);
    // R3: controller strobe with chip enable high
    cyc("R3", 1, 0, 1, 1, 0, 1, 1, 16'h2222);
    cyc("R8", 1, 1, 1, 0, 1, 1, 1, 16'h2222);
    // R11: controller start with write low
    cyc("R11", 1, 0, 0, 1, 0, 1, 0, 16'h8002);
    // R11: both strobes low, write ignored
    cyc("R11", 0, 0, 0, 1, 0, 1, 0, 16'h9001);
    cyc("R11", 1, 0, 0, 1, 0, 1, 1, 16'h9003);
    // R4: chip selects inactive
    cyc("R4", 0, 1, 0, 0, 0, 1, 1, 16'h3333);
    cyc("R5", 0, 1, 0, 1, 0, 1, 1, 16'h3331);
    cyc("R4", 1, 0, 0, 1, 1, 1, 1, 16'h3333);

    do_reset(1'b1);
    // R10: interleaved order from 10
    cyc("R10", 0, 1, 0, 1, 0, 1, 1, 16'hABCE);
    for (int i = 0; i < 4; i++) cyc("R10", 1, 1, 0, 1, 0, 0, 1, 16'h0);
    cyc("R10", 0, 1, 0, 1, 0, 1, 1, 16'h5551);
    for (int i = 0; i < 5; i++) cyc("R10", 1, 1, 1, 0, 1, 0, 1, 16'h0);

    for (int ph = 0; ph < 2; ph++) begin
      do_reset(ph[0]);
      for (int i = 0; i < 3000; i++) begin
        logic [15:0] r;
        r = 16'($urandom);
        cyc(ph[0] ? "R10" : "R9", ($urandom % 3) != 0, ($urandom % 4) != 0,
            ($urandom % 4) == 0, ($urandom % 6) != 0, ($urandom % 6) == 0,
            ($urandom % 3) == 0, $urandom % 2, r);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule